// File: doc/BRIEF.md
# Pixel Format Converter with Alpha Control

This block turns a stream of source pixels, one per beat, into 32-bit ARGB pixels laid out as alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. A static 4-bit format selector says how each incoming word is to be read. Direct-colour formats are widened to 8 bits per channel by repeating their upper bits. Indexed and luminance formats get their colour from an external lookup table through a synchronous read port. After that, an alpha stage can keep the pixel's alpha, replace it with a fixed value, or scale it by that value. It can then complement the alpha and exchange the red and blue channels.

Both sides of the block use valid/ready handshakes. The pipeline has two register stages, so a pixel accepted in cycle c appears on the output in cycle c+2, and backpressure from the output reaches the input in the same cycle. The configuration inputs are expected to stay constant while pixels are in flight. An illegal configuration raises an error flag and stops input acceptance.

Top module: `pfc_argb_convert`

## Requirements
- R1: Format code 0 takes in_pixel[31:0] as A,R,G,B bytes unchanged. Code 1 takes RGB from in_pixel[23:0] and sets alpha to 0xFF.
- R2: Format code 2 reads red from bits 15:11, green from 10:5 and blue from 4:0, widening each as {r,r[4:2]}, {g,g[5:4]}, {b,b[4:2]}. Alpha is 0xFF.
- R3: Format code 3 reads a 1-bit alpha at bit 15 (1 gives 0xFF, 0 gives 0x00) and 5-bit red, green, blue at 14:10, 9:5, 4:0, each widened as in R2.
- R4: Format code 4 reads 4-bit alpha, red, green, blue at 15:12, 11:8, 7:4, 3:0, each widened as {x,x}.
- R5: Format codes 5 (8-bit index at 7:0, alpha 0xFF), 6 (alpha nibble at 7:4, index at 3:0), 7 (alpha at 15:8, index at 7:0) and 8 (index at 3:0, alpha 0xFF) take red, green and blue from lut_data[23:16], [15:8] and [7:0]. lut_rd pulses with lut_addr equal to the index in the cycle such a pixel is accepted, and only then.
- R6: Format code 9 takes alpha from bits 7:0 and code 10 takes alpha from bits 3:0 widened as {x,x}. For both, red, green and blue are zero.
- R7: Alpha mode 0 keeps the pixel's alpha. Mode 1 replaces it with cfg_alpha.
- R8: Alpha mode 2 outputs the rounded product round(a*cfg_alpha/255), so 255*255 gives 255 and 0*x gives 0.
- R9: With cfg_ainv set, the output alpha is 255 minus the value from the alpha mode. With it clear, the alpha is unchanged.
- R10: With cfg_rbswap set, the output red and blue bytes are exchanged, including colours read from the table.
- R11: Format codes 11 to 15 or alpha mode 3 raise cfg_err. While cfg_err is high, in_ready is low, no pixel is taken and no lookup read is issued.
- R12: A pixel accepted in cycle c appears with out_valid high in cycle c+2 when out_ready is high. Back-to-back input is accepted every cycle with no gaps.
- R13: While out_valid is high and out_ready is low, out_valid and out_pixel hold. Every accepted pixel leaves exactly once and in order.
- R14: After reset, out_valid is low, and in_ready is high under a legal configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 4 | Source pixel format code |
| cfg_amode | input | 2 | Alpha policy: 0 keep, 1 replace, 2 multiply, 3 illegal |
| cfg_alpha | input | 8 | Fixed alpha value |
| cfg_ainv | input | 1 | Complement final alpha |
| cfg_rbswap | input | 1 | Exchange red and blue |
| cfg_err | output | 1 | Illegal configuration flag |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Source pixel accepted when high with in_valid |
| in_pixel | input | 32 | Source pixel, right-aligned |
| lut_rd | output | 1 | Lookup table read strobe |
| lut_addr | output | LUT_AW | Lookup table index |
| lut_data | input | 24 | Table RGB, valid the cycle after lut_rd and held until the next read |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output sink ready |
| out_pixel | output | 32 | ARGB8888 result |

## Verification
The bench builds the block with its default table index width of 8. This lets full 8-bit indices from formats 5 and 7 reach the table and also lets the bench check that 4-bit index formats leave the upper address bits at zero. The bench's table is a synchronous memory that returns a computed colour for every index. Mismatched index bits, stale reads and lost reads therefore show up as wrong colours. A streaming test with a repeating out_ready stall pattern exercises holding, ordering and throughput on the same configuration.

// File: rtl/pfc_pkg.sv
// Package: shared pixel types, code enumerations and the small arithmetic
// helpers used by the converter stages.
// Assumes 8-bit output channels; the input word is 32 bits wide.
package pfc_pkg;

    localparam int CH_W  = 8;
    localparam int PIX_W = 4 * CH_W;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    typedef enum logic [3:0] {
        FMT_ARGB32   = 4'd0,
        FMT_RGB24    = 4'd1,
        FMT_RGB16    = 4'd2,
        FMT_ARGB16A1 = 4'd3,
        FMT_ARGB16A4 = 4'd4,
        FMT_LUM8     = 4'd5,
        FMT_ALUM44   = 4'd6,
        FMT_ALUM88   = 4'd7,
        FMT_LUM4     = 4'd8,
        FMT_ALPHA8   = 4'd9,
        FMT_ALPHA4   = 4'd10
    } pix_fmt_e;

    localparam logic [3:0] FMT_LAST = 4'd10;

    typedef enum logic [1:0] {
        AM_KEEP    = 2'd0,
        AM_REPLACE = 2'd1,
        AM_SCALE   = 2'd2,
        AM_ILLEGAL = 2'd3
    } alpha_mode_e;

    // Widen a 5-bit field by repeating its top bits.
    function automatic logic [7:0] widen5(input logic [4:0] x);
        return {x, x[4:2]};
    endfunction

    // Widen a 6-bit field by repeating its top bits.
    function automatic logic [7:0] widen6(input logic [5:0] x);
        return {x, x[5:4]};
    endfunction

    // Widen a 4-bit field by doubling it.
    function automatic logic [7:0] widen4(input logic [3:0] x);
        return {x, x};
    endfunction

    // Rounded 8x8 product normalised back to 8 bits (x*y/255).
    function automatic logic [7:0] scale8(input logic [7:0] x, input logic [7:0] y);
        logic [15:0] prod;
        logic [15:0] biased;
        logic [15:0] sum;
        prod   = {8'd0, x} * {8'd0, y};
        biased = prod + 16'd128;
        sum    = biased + {8'd0, biased[15:8]};
        return 8'(sum >> 8);
    endfunction

endpackage

// File: rtl/pfc_cfg_check.sv
// Configuration checker: flags reserved format codes and the illegal alpha
// mode. Purely combinational; assumes the configuration is static.
module pfc_cfg_check
    import pfc_pkg::*;
(
    input  logic [3:0] fmt,
    input  logic [1:0] amode,
    output logic       err
);

    // Flag any code outside the decoded set.
    always_comb begin
        err = (fmt > FMT_LAST) || (amode == AM_ILLEGAL);
    end

endmodule

// File: rtl/pfc_unpack.sv
// Unpacker: reads one right-aligned source word in the selected format and
// produces widened ARGB channels, plus a table index and a flag saying the
// colour must come from the lookup table. Combinational.
// Assumes LUT_AW >= 8.
module pfc_unpack
    import pfc_pkg::*;
#(
    parameter int LUT_AW = 8
) (
    input  logic [3:0]        fmt,
    input  logic [PIX_W-1:0]  pix,
    output argb_t             px,
    output logic              use_lut,
    output logic [LUT_AW-1:0] idx
);

    logic [7:0] idx8;

    // Per-format field extraction and widening.
    always_comb begin
        px      = '0;
        use_lut = 1'b0;
        idx8    = 8'd0;
        case (fmt)
            FMT_ARGB32: begin
                px = pix;
            end
            FMT_RGB24: begin
                px.a = 8'hFF;
                px.r = pix[23:16];
                px.g = pix[15:8];
                px.b = pix[7:0];
            end
            FMT_RGB16: begin
                px.a = 8'hFF;
                px.r = widen5(pix[15:11]);
                px.g = widen6(pix[10:5]);
                px.b = widen5(pix[4:0]);
            end
            FMT_ARGB16A1: begin
                px.a = {8{pix[15]}};
                px.r = widen5(pix[14:10]);
                px.g = widen5(pix[9:5]);
                px.b = widen5(pix[4:0]);
            end
            FMT_ARGB16A4: begin
                px.a = widen4(pix[15:12]);
                px.r = widen4(pix[11:8]);
                px.g = widen4(pix[7:4]);
                px.b = widen4(pix[3:0]);
            end
            FMT_LUM8: begin
                px.a    = 8'hFF;
                use_lut = 1'b1;
                idx8    = pix[7:0];
            end
            FMT_ALUM44: begin
                px.a    = widen4(pix[7:4]);
                use_lut = 1'b1;
                idx8    = {4'd0, pix[3:0]};
            end
            FMT_ALUM88: begin
                px.a    = pix[15:8];
                use_lut = 1'b1;
                idx8    = pix[7:0];
            end
            FMT_LUM4: begin
                px.a    = 8'hFF;
                use_lut = 1'b1;
                idx8    = {4'd0, pix[3:0]};
            end
            FMT_ALPHA8: begin
                px.a = pix[7:0];
            end
            FMT_ALPHA4: begin
                px.a = widen4(pix[3:0]);
            end
            default: begin
                px = '0;
            end
        endcase
    end

    // Zero-extend the index onto the table address width.
    always_comb begin
        idx = LUT_AW'(idx8);
    end

endmodule

// File: rtl/pfc_alpha.sv
// Alpha and channel stage: applies the alpha policy (keep, replace, scale),
// optional complement, then optional red/blue exchange. Combinational.
// Assumes the illegal mode is filtered upstream; it behaves as keep here.
module pfc_alpha
    import pfc_pkg::*;
(
    input  argb_t      src,
    input  logic [1:0] amode,
    input  logic [7:0] fixed_a,
    input  logic       inv,
    input  logic       swap,
    output argb_t      dst
);

    logic [7:0] a_pol;
    logic [7:0] a_fin;

    // Select the alpha policy result.
    always_comb begin
        case (amode)
            AM_REPLACE: a_pol = fixed_a;
            AM_SCALE:   a_pol = scale8(src.a, fixed_a);
            default:    a_pol = src.a;
        endcase
    end

    // Optional complement of the policy result.
    always_comb begin
        a_fin = inv ? (8'hFF - a_pol) : a_pol;
    end

    // Assemble the output with optional red/blue exchange.
    always_comb begin
        dst.a = a_fin;
        dst.g = src.g;
        dst.r = swap ? src.b : src.r;
        dst.b = swap ? src.r : src.b;
    end

endmodule

// File: rtl/pfc_argb_convert.sv
// Top: two-stage valid/ready pipeline. Stage 1 registers the unpacked pixel
// while the synchronous table read is in progress; stage 2 merges the table
// colour, applies the alpha stage and registers the result.
// Assumes: configuration static while pixels are in flight; the table
// returns data the cycle after lut_rd and holds it until the next read.
module pfc_argb_convert
    import pfc_pkg::*;
#(
    parameter int LUT_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_fmt,
    input  logic [1:0]        cfg_amode,
    input  logic [7:0]        cfg_alpha,
    input  logic              cfg_ainv,
    input  logic              cfg_rbswap,
    output logic              cfg_err,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_pixel,
    output logic              lut_rd,
    output logic [LUT_AW-1:0] lut_addr,
    input  logic [23:0]       lut_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_pixel
);

    argb_t             up_px;
    logic              up_lut;
    logic [LUT_AW-1:0] up_idx;

    logic  s1_valid;
    argb_t s1_px;
    logic  s1_lut;
    argb_t mrg_px;
    argb_t alp_px;

    logic s1_adv;
    logic s2_adv;
    logic in_fire;

    pfc_cfg_check u_cfg (
        .fmt   (cfg_fmt),
        .amode (cfg_amode),
        .err   (cfg_err)
    );

    pfc_unpack #(.LUT_AW(LUT_AW)) u_unpack (
        .fmt     (cfg_fmt),
        .pix     (in_pixel),
        .px      (up_px),
        .use_lut (up_lut),
        .idx     (up_idx)
    );

    // Handshake: each stage advances when the stage after it can take data.
    always_comb begin
        s2_adv   = !out_valid || out_ready;
        s1_adv   = !s1_valid || s2_adv;
        in_ready = s1_adv && !cfg_err;
        in_fire  = in_valid && in_ready;
    end

    // Issue a table read only for accepted indexed pixels.
    always_comb begin
        lut_rd   = in_fire && up_lut;
        lut_addr = up_idx;
    end

    // Stage 1 occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)      s1_valid <= 1'b0;
        else if (s1_adv) s1_valid <= in_fire;
    end

    // Stage 1 payload.
    always_ff @(posedge clk) begin
        if (in_fire) begin
            s1_px  <= up_px;
            s1_lut <= up_lut;
        end
    end

    // Merge table colour for indexed pixels, keeping their own alpha.
    always_comb begin
        mrg_px = s1_px;
        if (s1_lut) begin
            mrg_px.r = lut_data[23:16];
            mrg_px.g = lut_data[15:8];
            mrg_px.b = lut_data[7:0];
        end
    end

    pfc_alpha u_alpha (
        .src     (mrg_px),
        .amode   (cfg_amode),
        .fixed_a (cfg_alpha),
        .inv     (cfg_ainv),
        .swap    (cfg_rbswap),
        .dst     (alp_px)
    );

    // Stage 2 occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_valid <= 1'b0;
        else if (s2_adv) out_valid <= s1_valid;
    end

    // Stage 2 payload.
    always_ff @(posedge clk) begin
        if (s2_adv && s1_valid) out_pixel <= alp_px;
    end

endmodule

// File: rtl/pfc_argb_convert_chk.sv
// Checker bound to the converter top: handshake, table port and
// configuration-error properties.
module pfc_argb_convert_chk #(
    parameter int LUT_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cfg_fmt,
    input logic              cfg_err,
    input logic              in_valid,
    input logic              in_ready,
    input logic              lut_rd,
    input logic [LUT_AW-1:0] lut_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [31:0]       out_pixel
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pixel)); // R13

    AST_CFG_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !in_ready && !lut_rd); // R11

    AST_LUT_RD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lut_rd |-> in_valid && in_ready); // R5

    AST_LUT_NARROW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        lut_rd && (cfg_fmt == 4'd8 || cfg_fmt == 4'd6) |-> lut_addr < LUT_AW'(16)); // R5

    AST_DIRECT_NO_LUT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fmt < 4'd5 |-> !lut_rd); // R5

    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2)); // R12

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R14

endmodule

bind pfc_argb_convert pfc_argb_convert_chk #(.LUT_AW(LUT_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_fmt   (cfg_fmt),
    .cfg_err   (cfg_err),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .lut_rd    (lut_rd),
    .lut_addr  (lut_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel)
);

// File: tb/pfc_argb_convert_tb.sv
`timescale 1ns/1ps
module pfc_argb_convert_tb;

    localparam int LUT_AW = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [3:0]        cfg_fmt;
    logic [1:0]        cfg_amode;
    logic [7:0]        cfg_alpha;
    logic              cfg_ainv;
    logic              cfg_rbswap;
    logic              cfg_err;
    logic              in_valid;
    logic              in_ready;
    logic [31:0]       in_pixel;
    logic              lut_rd;
    logic [LUT_AW-1:0] lut_addr;
    logic [23:0]       lut_data;
    logic              out_valid;
    logic              out_ready;
    logic [31:0]       out_pixel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pfc_argb_convert #(.LUT_AW(LUT_AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_fmt(cfg_fmt), .cfg_amode(cfg_amode), .cfg_alpha(cfg_alpha),
        .cfg_ainv(cfg_ainv), .cfg_rbswap(cfg_rbswap), .cfg_err(cfg_err),
        .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
        .lut_rd(lut_rd), .lut_addr(lut_addr), .lut_data(lut_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
    );

    // Table colour for an index, computed.
    function automatic logic [23:0] tbl(input logic [7:0] i);
        return {i ^ 8'h5A, ~i, i + 8'd17};
    endfunction

    // Synchronous table memory that holds its output between reads.
    always_ff @(posedge clk) begin
        if (lut_rd) lut_data <= tbl(lut_addr);
    end

    // Expected output from the requirements.
    function automatic logic [31:0] model(input logic [3:0] f, input logic [1:0] am,
                                          input logic [7:0] fa, input logic ai,
                                          input logic sw, input logic [31:0] p);
        logic [7:0] a, r, g, b, t;
        a = 8'hFF; r = 8'd0; g = 8'd0; b = 8'd0;
        case (f)
            4'd0:  {a, r, g, b} = p;
            4'd1:  {r, g, b} = p[23:0];
            4'd2:  begin r = {p[15:11], p[15:13]}; g = {p[10:5], p[10:9]}; b = {p[4:0], p[4:2]}; end
            4'd3:  begin a = p[15] ? 8'hFF : 8'h00; r = {p[14:10], p[14:12]};
                         g = {p[9:5], p[9:7]}; b = {p[4:0], p[4:2]}; end
            4'd4:  begin a = {2{p[15:12]}}; r = {2{p[11:8]}}; g = {2{p[7:4]}}; b = {2{p[3:0]}}; end
            4'd5:  {r, g, b} = tbl(p[7:0]);
            4'd6:  begin a = {2{p[7:4]}}; {r, g, b} = tbl({4'd0, p[3:0]}); end
            4'd7:  begin a = p[15:8]; {r, g, b} = tbl(p[7:0]); end
            4'd8:  {r, g, b} = tbl({4'd0, p[3:0]});
            4'd9:  a = p[7:0];
            4'd10: a = {2{p[3:0]}};
            default: a = 8'h00;
        endcase
        if (am == 2'd1) a = fa;
        else if (am == 2'd2) a = 8'((int'(a) * int'(fa) * 2 + 255) / 510);
        if (ai) a = 8'd255 - a;
        if (sw) begin t = r; r = b; b = t; end
        return {a, r, g, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] f, input logic [1:0] am, input logic [7:0] fa,
                           input logic ai, input logic sw);
        @(negedge clk);
        cfg_fmt = f; cfg_amode = am; cfg_alpha = fa; cfg_ainv = ai; cfg_rbswap = sw;
    endtask

    // Send one pixel with out_ready high; check table port and output at c+2.
    task automatic send_check(input string req, input logic [31:0] p);
        logic [31:0] exp;
        exp = model(cfg_fmt, cfg_amode, cfg_alpha, cfg_ainv, cfg_rbswap, p);
        @(negedge clk);
        in_valid = 1'b1; in_pixel = p; out_ready = 1'b1;
        #1;
        if (cfg_fmt >= 4'd5 && cfg_fmt <= 4'd8)
            chk({req, " lut addr"}, {31'd0, lut_rd} << 8 | 32'(lut_addr),
                32'h100 | ((cfg_fmt == 4'd6 || cfg_fmt == 4'd8) ? {28'd0, p[3:0]} : {24'd0, p[7:0]}));
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " not early"}, {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk(req, out_pixel, exp);
    endtask

    task automatic t_reset();
        #1;
        chk("R14 out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R14 in_ready after reset", {31'd0, in_ready}, 32'd1);
        chk("R14 cfg_err legal", {31'd0, cfg_err}, 32'd0);
    endtask

    task automatic t_direct();
        set_cfg(4'd0, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R1 argb32", 32'h12_34_56_78);
        set_cfg(4'd1, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R1 rgb24", 32'h99_AB_CD_EF);
        set_cfg(4'd2, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R2 rgb565 white", 32'h0000_FFFF);
        send_check("R2 rgb565 mix", 32'h0000_A5C3);
        set_cfg(4'd3, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R3 argb1555 a1", 32'h0000_D2B7);
        send_check("R3 argb1555 a0", 32'h0000_5A4E);
        set_cfg(4'd4, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R4 argb4444", 32'h0000_9C3E);
    endtask

    task automatic t_lut();
        set_cfg(4'd5, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R5 lum8", 32'h0000_00C7);
        set_cfg(4'd6, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R5 alum44", 32'h0000_00B9);
        set_cfg(4'd7, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R5 alum88", 32'h0000_3EF2);
        set_cfg(4'd8, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R5 lum4", 32'h0000_00FD);
    endtask

    task automatic t_alpha_only();
        set_cfg(4'd9, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R6 alpha8", 32'hFFFF_FF6B);
        set_cfg(4'd10, 2'd0, 8'h00, 1'b0, 1'b0);
        send_check("R6 alpha4", 32'hFFFF_FFF5);
    endtask

    task automatic t_alpha_modes();
        set_cfg(4'd0, 2'd1, 8'h3C, 1'b0, 1'b0);
        send_check("R7 replace", 32'hE0_11_22_33);
        set_cfg(4'd0, 2'd2, 8'hFF, 1'b0, 1'b0);
        send_check("R8 scale 255x255", 32'hFF_11_22_33);
        chk("R8 scale 255x255 const", out_pixel, 32'hFF_11_22_33);
        set_cfg(4'd0, 2'd2, 8'h80, 1'b0, 1'b0);
        send_check("R8 scale 255x128", 32'hFF_01_02_03);
        send_check("R8 scale 0x128", 32'h00_01_02_03);
        send_check("R8 scale 77x128", 32'h4D_01_02_03);
        set_cfg(4'd7, 2'd2, 8'hC8, 1'b0, 1'b0);
        send_check("R8 scale alum88", 32'h0000_6419);
    endtask

    task automatic t_inv_swap();
        set_cfg(4'd0, 2'd0, 8'h00, 1'b1, 1'b0);
        send_check("R9 invert keep", 32'h30_AA_BB_CC);
        set_cfg(4'd0, 2'd0, 8'h00, 1'b0, 1'b1);
        send_check("R10 swap", 32'h30_AA_BB_CC);
        set_cfg(4'd5, 2'd1, 8'h21, 1'b1, 1'b1);
        send_check("R9 R10 lum8 inv swap", 32'h0000_0042);
    endtask

    task automatic t_cfg_err();
        set_cfg(4'd11, 2'd0, 8'h00, 1'b0, 1'b0);
        #1;
        chk("R11 err fmt11", {31'd0, cfg_err}, 32'd1);
        chk("R11 ready fmt11", {31'd0, in_ready}, 32'd0);
        set_cfg(4'd15, 2'd0, 8'h00, 1'b0, 1'b0);
        #1;
        chk("R11 err fmt15", {31'd0, cfg_err}, 32'd1);
        set_cfg(4'd5, 2'd3, 8'h00, 1'b0, 1'b0);
        #1;
        chk("R11 err amode3", {31'd0, cfg_err}, 32'd1);
        in_valid = 1'b1; in_pixel = 32'h0000_0011; out_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk("R11 blocked ready", {31'd0, in_ready}, 32'd0);
            chk("R11 no lut read", {31'd0, lut_rd}, 32'd0);
            chk("R11 no output", {31'd0, out_valid}, 32'd0);
        end
        in_valid = 1'b0;
        set_cfg(4'd5, 2'd0, 8'h00, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk("R11 nothing taken", {31'd0, out_valid}, 32'd0);
        end
        chk("R11 ready restored", {31'd0, in_ready}, 32'd1);
    endtask

    // Stream n pixels; stall_en applies a repeating out_ready pattern.
    task automatic t_stream(input string req, input bit stall_en, input int n);
        logic [31:0] src [16];
        int sent = 0, got = 0, waits = 0, cyc = 0;
        logic        prev_stall = 1'b0;
        logic [31:0] prev_pix = '0;
        for (int k = 0; k < n; k++) src[k] = 32'h0000_1000 * k + 32'h0000_0137 * (k + 3);
        set_cfg(4'd7, 2'd2, 8'h80, 1'b0, 1'b1);
        fork
            begin
                while (sent < n) begin
                    @(negedge clk); #2;
                    in_valid = 1'b1; in_pixel = src[sent];
                    if (in_ready) sent++; else waits++;
                end
                @(negedge clk); #2;
                in_valid = 1'b0;
            end
            begin
                while (got < n && cyc < 200) begin
                    @(negedge clk);
                    cyc++;
                    if (prev_stall) begin
                        chk({req, " hold valid"}, {31'd0, out_valid}, 32'd1);
                        chk({req, " hold data"}, out_pixel, prev_pix);
                    end
                    out_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
                    if (out_valid && out_ready) begin
                        chk(req, out_pixel, model(4'd7, 2'd2, 8'h80, 1'b0, 1'b1, src[got]));
                        got++;
                    end
                    prev_stall = out_valid && !out_ready;
                    prev_pix   = out_pixel;
                end
                chk({req, " count"}, 32'(got), 32'(n));
            end
        join
        if (!stall_en) chk({req, " no input gaps"}, 32'(waits), 32'd0);
        @(negedge clk); out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk({req, " drained"}, {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_pixel = '0; out_ready = 1'b1;
        cfg_fmt = 4'd0; cfg_amode = 2'd0; cfg_alpha = 8'h00; cfg_ainv = 1'b0; cfg_rbswap = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_lut();
        t_alpha_only();
        t_alpha_modes();
        t_inv_swap();
        t_cfg_err();
        t_stream("R12 stream full rate", 1'b0, 10);
        t_stream("R13 stream backpressure", 1'b1, 12);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule